// File: doc/BRIEF.md
# Hierarchical Ring-Mesh Route Computation

This unit picks the output channel for a packet in a two-level on-chip network. Four router nodes are wired into a small ring, and the rings are tiled as a 2D mesh. Each node has three network links: two toward its ring neighbours and one toward the mesh. The direction of that single mesh link depends on where the node sits in its ring. A packet that must cross the mesh therefore first circles its ring until it reaches the node whose mesh link faces the way it needs to go.

The unit is purely combinational. It takes the current node address and the destination address, each made of a mesh column, a mesh row and a ring position 0..3, plus a request-valid bit. It returns a one-hot channel select and an echoed valid. The decision is deterministic and uses nothing but the two addresses. Column differences are always resolved before row differences. Mesh dimensions are parameters, and the column and row fields are sized from them.

Top module: `hrm_route_unit`

## Requirements
- R1: With the destination column below the current column, the select is M at position 0, C1 at position 3 and C0 at positions 1 and 2.
- R2: With the destination column above the current column, the select is M at position 2, C1 at position 1 and C0 at positions 0 and 3.
- R3: With equal columns and the destination row below the current row, the select is M at position 3, C0 at position 0 and C1 at positions 1 and 2.
- R4: With equal columns and the destination row above the current row, the select is M at position 1, C0 at position 2 and C1 at positions 0 and 3.
- R5: While the columns differ, the rows have no influence on the select (the R1/R2 rule applies whatever the rows are), and L is never chosen.
- R6: With column and row equal, the ring offset is (destination position − current position) mod 4. An offset of 0 selects L.
- R7: With column and row equal and a ring offset of 1 or 3, the select is C1 at an even current position and C0 at an odd one.
- R8: With column and row equal and a ring offset of 2, the select is C1 at an odd current position and C0 at an even one.
- R9: `sel_port` bits are ordered {L, M, C0, C1} from bit 3 down to bit 0. When `req_valid` is 1, exactly one bit is set and `sel_valid` is 1. When `req_valid` is 0, `sel_port` is 0 and `sel_valid` is 0.
- R10: The network is built with C1 leading to ring position (z+1) mod 4 and C0 to (z−1) mod 4. The mesh link of position 0 leads to column−1 landing at position 2, position 2 leads to column+1 landing at position 0, position 3 leads to row−1 landing at position 1, and position 1 leads to row+1 landing at position 3. In that network, following the selected channels from any node delivers to any destination, with L chosen there, in at most 3·(|Δcol|+|Δrow|)+3 hops, and never uses a mesh link off the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_valid | input | 1 | A routing request is present |
| cur_col | input | $clog2(COLS) (min 1) | Mesh column of the current node |
| cur_row | input | $clog2(ROWS) (min 1) | Mesh row of the current node |
| cur_pos | input | 2 | Ring position of the current node |
| dst_col | input | $clog2(COLS) (min 1) | Mesh column of the destination |
| dst_row | input | $clog2(ROWS) (min 1) | Mesh row of the destination |
| dst_pos | input | 2 | Ring position of the destination |
| sel_valid | output | 1 | Echo of req_valid |
| sel_port | output | 4 | One-hot channel select {L, M, C0, C1} |

## Verification
Every result is combinational, so the select and the valid echo are due in the same cycle as the address that causes them. The bench applies a new address pair on each falling clock edge and samples the outputs 2 ns later, before the next rising edge. It compares them there against a behavioural model of R1 to R8. For R10 the bench walks every source/destination pair of a 4x4 array of rings hop by hop, one hop per cycle, following the select the unit returns, and checks that delivery happens within the hop bound.

// File: rtl/hrm_route_pkg.sv
package hrm_route_pkg;

   // Channel code: the one-hot select has bit (code) set.
   typedef enum logic [1:0] {
      PORT_C1 = 2'd0,
      PORT_C0 = 2'd1,
      PORT_M  = 2'd2,
      PORT_L  = 2'd3
   } port_e;

   // Required travel direction derived from the address comparison.
   typedef enum logic [2:0] {
      HEAD_WEST  = 3'd0,
      HEAD_EAST  = 3'd1,
      HEAD_NORTH = 3'd2,
      HEAD_SOUTH = 3'd3,
      HEAD_HOME  = 3'd4
   } head_e;

   // Ring position whose mesh link faces each direction.
   localparam logic [1:0] FACE_WEST  = 2'd0;
   localparam logic [1:0] FACE_EAST  = 2'd2;
   localparam logic [1:0] FACE_NORTH = 2'd3;
   localparam logic [1:0] FACE_SOUTH = 2'd1;

   localparam int RING_NODES = 4;
   localparam int POS_W      = 2;
   localparam int NUM_PORTS  = 4;

   function automatic int field_width(input int extent);
      return (extent > 1) ? $clog2(extent) : 1;
   endfunction

endpackage

// File: rtl/hrm_dim_cmp.sv
module hrm_dim_cmp #(
   parameter int EXTENT = 8,
   localparam int W = hrm_route_pkg::field_width(EXTENT)
) (
   input  logic [W-1:0] here,
   input  logic [W-1:0] there,
   output logic         there_lo,
   output logic         there_hi
);
   generate
      if (EXTENT == 1) begin : g_flat
         // A single-entry dimension never differs.
         assign there_lo = 1'b0;
         assign there_hi = 1'b0;
         logic unused_flat;
         assign unused_flat = ^{here, there};
      end else begin : g_cmp
         assign there_lo = (there < here);
         assign there_hi = (there > here);
      end
   endgenerate
endmodule

// File: rtl/hrm_ring_sel.sv
module hrm_ring_sel
   import hrm_route_pkg::*;
(
   input  head_e            head,
   input  logic [POS_W-1:0] z_cur,
   input  logic [POS_W-1:0] z_dst,
   output port_e            port
);
   logic [POS_W-1:0] face;
   logic [POS_W-1:0] off;
   logic             x_phase;

   always_comb begin
      unique case (head)
         HEAD_WEST:  face = FACE_WEST;
         HEAD_EAST:  face = FACE_EAST;
         HEAD_NORTH: face = FACE_NORTH;
         HEAD_SOUTH: face = FACE_SOUTH;
         default:    face = '0;
      endcase
   end

   assign x_phase = (head == HEAD_WEST) || (head == HEAD_EAST);
   assign off     = z_dst - z_cur;

   always_comb begin
      port = PORT_L;
      if (head == HEAD_HOME) begin
         if (off == 2'd0)
            port = PORT_L;
         else if (off[0])
            port = z_cur[0] ? PORT_C0 : PORT_C1;
         else
            port = z_cur[0] ? PORT_C1 : PORT_C0;
      end else if (z_cur == face) begin
         port = PORT_M;
      end else if (x_phase) begin
         // Column phase: only the node just below the facing one steps up.
         port = (z_cur == face - 2'd1) ? PORT_C1 : PORT_C0;
      end else begin
         // Row phase: only the node just above the facing one steps down.
         port = (z_cur == face + 2'd1) ? PORT_C0 : PORT_C1;
      end
   end
endmodule

// File: rtl/hrm_port_enc.sv
module hrm_port_enc
   import hrm_route_pkg::*;
(
   input  logic                 en,
   input  port_e                port,
   output logic [NUM_PORTS-1:0] onehot
);
   generate
      for (genvar k = 0; k < NUM_PORTS; k++) begin : g_bit
         assign onehot[k] = en && (port == port_e'(k));
      end
   endgenerate
endmodule

// File: rtl/hrm_route_unit.sv
module hrm_route_unit
   import hrm_route_pkg::*;
#(
   parameter int COLS = 8,
   parameter int ROWS = 8,
   localparam int XW = field_width(COLS),
   localparam int YW = field_width(ROWS)
) (
   input  logic                 req_valid,
   input  logic [XW-1:0]        cur_col,
   input  logic [YW-1:0]        cur_row,
   input  logic [POS_W-1:0]     cur_pos,
   input  logic [XW-1:0]        dst_col,
   input  logic [YW-1:0]        dst_row,
   input  logic [POS_W-1:0]     dst_pos,
   output logic                 sel_valid,
   output logic [NUM_PORTS-1:0] sel_port
);
   generate
      if (COLS < 1) begin : g_bad_cols
         $error("hrm_route_unit: COLS must be at least 1");
      end
      if (ROWS < 1) begin : g_bad_rows
         $error("hrm_route_unit: ROWS must be at least 1");
      end
   endgenerate

   logic  col_lo, col_hi, row_lo, row_hi;
   head_e head;
   port_e port;

   hrm_dim_cmp #(.EXTENT(COLS)) u_col_cmp (
      .here(cur_col), .there(dst_col), .there_lo(col_lo), .there_hi(col_hi)
   );

   hrm_dim_cmp #(.EXTENT(ROWS)) u_row_cmp (
      .here(cur_row), .there(dst_row), .there_lo(row_lo), .there_hi(row_hi)
   );

   // Column first: the row comparison matters only once the columns agree.
   always_comb begin
      if (col_lo)      head = HEAD_WEST;
      else if (col_hi) head = HEAD_EAST;
      else if (row_lo) head = HEAD_NORTH;
      else if (row_hi) head = HEAD_SOUTH;
      else             head = HEAD_HOME;
   end

   hrm_ring_sel u_ring_sel (
      .head(head), .z_cur(cur_pos), .z_dst(dst_pos), .port(port)
   );

   hrm_port_enc u_enc (
      .en(req_valid), .port(port), .onehot(sel_port)
   );

   assign sel_valid = req_valid;

   always_comb begin
      if (req_valid === 1'b1) begin
         a_r9_onehot: assert ($onehot(sel_port) && sel_valid);
         if (dst_col < cur_col && cur_pos == 2'd0)
            a_r1_west_exit: assert (sel_port == 4'b0100);
         if (dst_col > cur_col && cur_pos == 2'd2)
            a_r2_east_exit: assert (sel_port == 4'b0100);
         if (dst_col == cur_col && dst_row < cur_row && cur_pos == 2'd3)
            a_r3_north_exit: assert (sel_port == 4'b0100);
         if (dst_col != cur_col)
            a_r5_col_first: assert (sel_port[3] == 1'b0);
         if (dst_col == cur_col && dst_row == cur_row && dst_pos == cur_pos)
            a_r6_deliver: assert (sel_port == 4'b1000);
      end else if (req_valid === 1'b0) begin
         a_r9_idle: assert (sel_port == '0 && !sel_valid);
      end
   end
endmodule

// File: tb/tb_hrm_route_unit.sv
module tb_hrm_route_unit;
   localparam int COLS = 4;
   localparam int ROWS = 4;

   logic       clk = 1'b0;
   logic       req_valid;
   logic [1:0] cur_col, cur_row, cur_pos, dst_col, dst_row, dst_pos;
   logic       sel_valid;
   logic [3:0] sel_port;

   int n_vec  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;   // 125 MHz

   hrm_route_unit #(.COLS(COLS), .ROWS(ROWS)) dut (
      .req_valid(req_valid),
      .cur_col(cur_col), .cur_row(cur_row), .cur_pos(cur_pos),
      .dst_col(dst_col), .dst_row(dst_row), .dst_pos(dst_pos),
      .sel_valid(sel_valid), .sel_port(sel_port)
   );

   task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   // Behavioural model, {L,M,C0,C1}.
   function automatic logic [3:0] model(input int cx, input int cy, input int cz,
                                        input int dx, input int dy, input int dz,
                                        output string tag);
      int off;
      if (dx < cx) begin
         tag = (dy != cy) ? "R5" : "R1";
         if (cz == 0) return 4'b0100;
         if (cz == 3) return 4'b0001;
         return 4'b0010;
      end
      if (dx > cx) begin
         tag = (dy != cy) ? "R5" : "R2";
         if (cz == 2) return 4'b0100;
         if (cz == 1) return 4'b0001;
         return 4'b0010;
      end
      if (dy < cy) begin
         tag = "R3";
         if (cz == 3) return 4'b0100;
         if (cz == 0) return 4'b0010;
         return 4'b0001;
      end
      if (dy > cy) begin
         tag = "R4";
         if (cz == 1) return 4'b0100;
         if (cz == 2) return 4'b0010;
         return 4'b0001;
      end
      off = (dz - cz + 4) % 4;
      if (off == 0) begin
         tag = "R6";
         return 4'b1000;
      end
      if (off == 2) begin
         tag = "R8";
         return (cz % 2 == 1) ? 4'b0001 : 4'b0010;
      end
      tag = "R7";
      return (cz % 2 == 0) ? 4'b0001 : 4'b0010;
   endfunction

   task automatic apply(input logic v, input int cx, input int cy, input int cz,
                        input int dx, input int dy, input int dz);
      @(negedge clk);
      req_valid = v;
      cur_col = 2'(cx); cur_row = 2'(cy); cur_pos = 2'(cz);
      dst_col = 2'(dx); dst_row = 2'(dy); dst_pos = 2'(dz);
      #2;
   endtask

   task automatic run_all();
      string tag;
      logic [3:0] exp;
      // R9: idle requests give no select.
      apply(1'b0, 0, 0, 0, 0, 0, 0);
      check("R9 idle", {sel_valid, sel_port}, 5'b0_0000);
      apply(1'b0, 3, 1, 2, 0, 2, 1);
      check("R9 idle", {sel_valid, sel_port}, 5'b0_0000);
      // R10: walk every pair, checking R1..R9 at every hop.
      for (int s = 0; s < 64; s++) begin
         for (int d = 0; d < 64; d++) begin
            int cx = s % 4, cy = (s / 4) % 4, cz = s / 16;
            int dx = d % 4, dy = (d / 4) % 4, dz = d / 16;
            int limit = 3 * ((dx > cx ? dx - cx : cx - dx) + (dy > cy ? dy - cy : cy - dy)) + 3;
            int hops = 0;
            bit done = 0;
            bit broken = 0;
            while (!done && !broken && hops <= limit) begin
               apply(1'b1, cx, cy, cz, dx, dy, dz);
               exp = model(cx, cy, cz, dx, dy, dz, tag);
               check(tag, {sel_valid, sel_port}, {1'b1, exp});
               case (sel_port)
                  4'b1000: done = (cx == dx && cy == dy && cz == dz);
                  4'b0001: begin cz = (cz + 1) % 4; hops++; end
                  4'b0010: begin cz = (cz + 3) % 4; hops++; end
                  4'b0100: begin
                     hops++;
                     case (cz)
                        0: begin if (cx == 0) broken = 1; else begin cx--; cz = 2; end end
                        2: begin if (cx == COLS - 1) broken = 1; else begin cx++; cz = 0; end end
                        3: begin if (cy == 0) broken = 1; else begin cy--; cz = 1; end end
                        default: begin if (cy == ROWS - 1) broken = 1; else begin cy++; cz = 3; end end
                     endcase
                  end
                  default: broken = 1;
               endcase
               if (sel_port == 4'b1000 && !done) broken = 1;
            end
            check("R10 delivery", {4'b0, done && !broken}, 5'b0_0001);
         end
      end
      apply(1'b0, 1, 1, 1, 2, 2, 2);
      check("R9 idle after", {sel_valid, sel_port}, 5'b0_0000);
   endtask

   initial begin
      req_valid = 1'b0;
      cur_col = '0; cur_row = '0; cur_pos = '0;
      dst_col = '0; dst_row = '0; dst_pos = '0;
      fork
         run_all();
         begin
            repeat (190000) @(posedge clk);
            n_vec++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule